// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block collects level-sensitive interrupt pins from a row of device slots, folds them onto four shared interrupt lines, and steers each shared line onto one input of a 16-input legacy interrupt controller. Each slot has four pins (A, B, C, D). A slot's pins are rotated by its slot number before they reach the shared lines, so devices that only use pin A still spread across different lines.

Four 8-bit route registers, one per shared line, hold the legacy input number that the line drives. A value of 16 or more parks the line, and it then drives nothing. A legacy output is high when any shared line routed to it is high. The routes come out of reset in one of two profiles chosen by a strap input: all parked, or a fixed split onto inputs 10 and 11. The route registers can be written and read back through a small register port. The output vector is combinational from the stored routes and the live pin levels.

Top module: `irq_line_router`

## Requirements
- R1: Input bit `dev_irq[s*4+p]` is slot index s, pin p (A=0 to D=3). It has slot number `FIRST_SLOT+s` and drives shared line `(p + slot number - 1) mod 4`.
- R2: A shared line is high when any slot/pin input mapped onto it is high.
- R3: When route register k holds a value v below 16, `pic_irq[v]` is high if any shared line routed to v is high. Two or more lines routed to the same v are ORed.
- R4: A route value of 16 or more disables that line, so it drives no `pic_irq` bit.
- R5: When reset is taken with `profile_sel`=0, all four route registers read 0x80.
- R6: When reset is taken with `profile_sel`=1, route registers 0 to 3 read 0x0A, 0x0A, 0x0B and 0x0B.
- R7: A write with `cfg_wr`=1 stores `cfg_wdata` into route register `cfg_addr` at the clock edge. It takes effect from the next cycle. `cfg_rdata` returns that exact value, including disabled values, and the other registers are left unchanged.
- R8: While reset is asserted, and for two clock edges after it is released, `pic_irq` is all zero.
- R9: After reset, a change on `dev_irq` appears on `pic_irq` within the same cycle, with no clock edge needed. After a route write, the new mapping applies to the levels already present, without any toggle of the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| profile_sel | input | 1 | Reset profile strap: 0 = all lines parked, 1 = split onto inputs 10 and 11 |
| cfg_wr | input | 1 | Route register write strobe |
| cfg_addr | input | 2 | Route register index (shared line number) |
| cfg_wdata | input | 8 | Route register write data |
| cfg_rdata | output | 8 | Route register addressed by `cfg_addr` |
| dev_irq | input | NUM_SLOTS*4 | Device interrupt levels, slot-major, four pins per slot |
| pic_irq | output | 16 | Legacy interrupt controller input levels |

## Verification
Single-hot `dev_irq` patterns walk every slot and pin. Each one shows which shared line the rotation picks, and so which legacy bit rises under distinct routes. Random multi-bit input vectors, applied under random route sets, check the OR on shared lines and on outputs. These route sets often send several lines to the same legacy number and mix in parked values of 16 and above. Directed cases cover:
- both reset profiles;
- the boundary values 15 and 16;
- a route rewrite while inputs are held steady, which shows the output moving with no input change.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int PINS_PER_SLOT = 4;
  localparam int NUM_LINES     = 4;
  localparam int ROUTE_W       = 8;
  localparam int LINE_IDX_W    = $clog2(NUM_LINES);

  typedef logic [ROUTE_W-1:0] route_t;

  localparam route_t PARKED_ROUTE = 8'h80;

  function automatic route_t profile_route(input logic alt, input int line);
    if (!alt) return PARKED_ROUTE;
    return (line < 2) ? route_t'(8'h0A) : route_t'(8'h0B);
  endfunction
endpackage

// File: rtl/irq_pin_swizzle.sv
module irq_pin_swizzle
  import irq_router_pkg::*;
#(
  parameter int NUM_SLOTS  = 6,
  parameter int FIRST_SLOT = 1
) (
  input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] dev_irq,
  output logic [NUM_LINES-1:0]               line_lvl
);
  always_comb begin
    line_lvl = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      for (int p = 0; p < PINS_PER_SLOT; p++) begin
        line_lvl[LINE_IDX_W'((p + FIRST_SLOT + s + NUM_LINES - 1) % NUM_LINES)] |=
          dev_irq[s*PINS_PER_SLOT + p];
      end
    end
  end

  // R2: activity on any pin must reach some shared line and nothing else
  always_comb begin
    a_r2_any_pin_reaches_line: assert ((|dev_irq) == (|line_lvl));
  end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_router_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           profile_sel,
  input  logic                           wr_en,
  input  logic [LINE_IDX_W-1:0]          wr_addr,
  input  route_t                         wr_data,
  output logic [NUM_LINES-1:0][ROUTE_W-1:0] routes
);
  logic [NUM_LINES-1:0][ROUTE_W-1:0] routes_d;
  logic [NUM_LINES-1:0]              load_en;

  always_comb begin
    for (int l = 0; l < NUM_LINES; l++) begin
      load_en[l]  = wr_en && (wr_addr == LINE_IDX_W'(l));
      routes_d[l] = wr_data;
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          routes[g] <= profile_route(profile_sel, g);
      else if (load_en[g]) routes[g] <= routes_d[g];
    end
  end

  // R7: a write lands in the addressed register on the next cycle
  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> routes[$past(wr_addr)] == $past(wr_data));
  // R7: without a write, routes hold
  a_r7_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(routes));
endmodule

// File: rtl/irq_line_fanout.sv
module irq_line_fanout
  import irq_router_pkg::*;
#(
  parameter int NUM_OUTS = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_LINES-1:0][ROUTE_W-1:0] routes,
  input  logic [NUM_LINES-1:0]              line_lvl,
  output logic [NUM_OUTS-1:0]               out_lvl
);
  for (genvar o = 0; o < NUM_OUTS; o++) begin : g_out
    logic [NUM_LINES-1:0] hit;
    always_comb begin
      for (int l = 0; l < NUM_LINES; l++) begin
        hit[l] = (routes[l] == ROUTE_W'(o));
      end
      out_lvl[o] = |(hit & line_lvl);
    end
  end

  logic all_parked;
  always_comb begin
    all_parked = 1'b1;
    for (int l = 0; l < NUM_LINES; l++) begin
      if (routes[l] < ROUTE_W'(NUM_OUTS)) all_parked = 1'b0;
    end
  end

  // R4: with every line parked no output may rise
  a_r4_parked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    all_parked |-> out_lvl == '0);
  // R3: an output can only be high if some shared line is high
  a_r3_out_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_lvl) |-> (|line_lvl));
endmodule

// File: rtl/irq_line_router.sv
module irq_line_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SLOTS  = 6,
  parameter int FIRST_SLOT = 1,
  parameter int NUM_OUTS   = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               profile_sel,
  input  logic                               cfg_wr,
  input  logic [1:0]                         cfg_addr,
  input  logic [7:0]                         cfg_wdata,
  output logic [7:0]                         cfg_rdata,
  input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] dev_irq,
  output logic [NUM_OUTS-1:0]                pic_irq
);
  logic [1:0] rst_sync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  logic [NUM_LINES-1:0][ROUTE_W-1:0] routes;
  logic [NUM_LINES-1:0]              line_lvl;
  logic [NUM_OUTS-1:0]               out_raw;

  irq_route_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_ok),
    .profile_sel (profile_sel),
    .wr_en       (cfg_wr),
    .wr_addr     (cfg_addr),
    .wr_data     (cfg_wdata),
    .routes      (routes)
  );

  irq_pin_swizzle #(.NUM_SLOTS(NUM_SLOTS), .FIRST_SLOT(FIRST_SLOT)) u_swz (
    .dev_irq  (dev_irq),
    .line_lvl (line_lvl)
  );

  irq_line_fanout #(.NUM_OUTS(NUM_OUTS)) u_fan (
    .clk      (clk),
    .rst_n    (rst_ok),
    .routes   (routes),
    .line_lvl (line_lvl),
    .out_lvl  (out_raw)
  );

  assign cfg_rdata = routes[cfg_addr];
  assign pic_irq   = rst_ok ? out_raw : '0;

  // R8: outputs stay quiet while the synchronized reset is held
  a_r8_quiet_in_reset: assert property (@(posedge clk)
    !rst_ok |-> pic_irq == '0);
  // R5/R6: the first cycle out of reset shows a profile value on line 0
  a_r5_profile_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_ok) |-> (routes[0] == 8'h80 || routes[0] == 8'h0A));
endmodule

// File: tb/tb_irq_line_router.sv
module tb_irq_line_router;
  localparam int NS = 6;
  localparam int FS = 1;
  localparam int NO = 16;

  logic clk = 0;
  logic rst_n, profile_sel, cfg_wr;
  logic [1:0] cfg_addr;
  logic [7:0] cfg_wdata, cfg_rdata;
  logic [NS*4-1:0] dev_irq;
  logic [NO-1:0] pic_irq;

  int total = 0, bad = 0;
  logic [7:0] mdl_route [4];

  always #10 clk = ~clk;

  irq_line_router #(.NUM_SLOTS(NS), .FIRST_SLOT(FS), .NUM_OUTS(NO)) dut (
    .clk(clk), .rst_n(rst_n), .profile_sel(profile_sel), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .dev_irq(dev_irq), .pic_irq(pic_irq));

  function automatic logic [3:0] exp_lines(input logic [NS*4-1:0] d);
    logic [3:0] l = '0;
    for (int s = 0; s < NS; s++)
      for (int p = 0; p < 4; p++)
        if (d[s*4+p]) l[(p + FS + s - 1 + 4) % 4] = 1'b1;
    return l;
  endfunction

  function automatic logic [NO-1:0] exp_out(input logic [NS*4-1:0] d);
    logic [NO-1:0] o = '0;
    logic [3:0] l = exp_lines(d);
    for (int k = 0; k < 4; k++)
      if (l[k] && mdl_route[k] < NO) o[mdl_route[k]] = 1'b1;
    return o;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic prof);
    @(negedge clk);
    rst_n = 0; profile_sel = prof; cfg_wr = 0; cfg_addr = 0; cfg_wdata = 0;
    dev_irq = '1;
    #1 check("R8 out in reset", 32'(pic_irq), 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1 check("R8 out one edge after release", 32'(pic_irq), 0);
    @(negedge clk);
    dev_irq = '0;
    for (int k = 0; k < 4; k++)
      mdl_route[k] = prof ? ((k < 2) ? 8'h0A : 8'h0B) : 8'h80;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 0;
    mdl_route[a] = v;
  endtask

  task automatic check_regs(input string req);
    for (int k = 0; k < 4; k++) begin
      cfg_addr = 2'(k);
      #1 check(req, 32'(cfg_rdata), 32'(mdl_route[k]));
    end
  endtask

  task automatic check_out(input string req, input logic [NS*4-1:0] d);
    dev_irq = d;
    #1 check(req, 32'(pic_irq), 32'(exp_out(d)));
  endtask

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D5EED));
    rst_n = 0; profile_sel = 0; cfg_wr = 0; cfg_addr = 0; cfg_wdata = 0; dev_irq = '0;

    do_reset(1'b0);
    check_regs("R5 parked profile");
    check_out("R4 parked all inputs high", '1);

    do_reset(1'b1);
    check_regs("R6 alt profile");
    // slot 0 (number 1) pin A -> line 0 -> input 10
    check_out("R1 slot0 pinA to irq10", 24'h000001);
    // slot 1 (number 2) pin A -> line 1 -> input 10; pin B -> line 2 -> 11
    check_out("R1 slot1 pinB to irq11", 24'h000020);

    // distinct routes: line k -> input k+1
    for (int k = 0; k < 4; k++) wr(2'(k), 8'(k + 1));
    check_regs("R7 readback");
    for (int b = 0; b < NS*4; b++) begin
      @(negedge clk);
      check_out("R1 walking pin", 24'(1) << b);
    end

    // R9: hold inputs, rewrite route, output moves without input toggle
    @(negedge clk);
    dev_irq = 24'h000001;  // line 0
    wr(2'd0, 8'd15);
    #1 check("R9 reroute no toggle", 32'(pic_irq), 32'h8000);
    wr(2'd0, 8'd16);
    #1 check("R4 boundary 16 parked", 32'(pic_irq), 0);
    check_regs("R7 disabled value readback");

    // R9: input change seen without a clock edge
    wr(2'd1, 8'd3);
    @(posedge clk); #3;
    dev_irq = 24'h000002;  // slot0 pinB -> line 1
    #1 check("R9 comb path", 32'(pic_irq), 32'h0008);

    // R3 wired-OR: all lines to input 7
    for (int k = 0; k < 4; k++) wr(2'(k), 8'd7);
    @(negedge clk);
    check_out("R3 shared target", 24'h100000);

    for (int it = 0; it < 300; it++) begin
      if (it % 5 == 0) begin
        logic [7:0] v = 8'($urandom);
        if ($urandom % 4 != 0) v = 8'($urandom % 16);
        wr(2'($urandom), v);
        check_regs("R7 random readback");
      end
      @(negedge clk);
      check_out("R2 R3 random", 24'($urandom) & 24'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule